// File: doc/BRIEF.md
# DRAM Command Decoder and Bank Tracker

This block watches the command pins of a double-data-rate DRAM interface on every rising clock edge. It turns the clock-enable, chip-select, row-strobe, column-strobe and write-enable pins, the two bank-select bits and address bit 10 into one command code. It also keeps a small state machine for each of four banks. Each bank moves through idle, activating, active, reading, writing and precharging, with timers for the activate-to-access delay, the burst length and the precharge time.

Each command is checked against the bank states held before it. A command that breaks the rules raises a one-cycle illegal flag and leaves every bank untouched. The rules cover a mode register write while a bank is open, an access to a bank that is not open, and a burst stop during a write burst. The block is meant for a controller-side protocol monitor or a memory model front end. The command code, the illegal flag, a power-down flag and the packed per-bank states are registered, so each shows the command sampled at the previous edge.

Top module: `dram_cmd_tracker`

## Requirements
- R1: `cmd_o` shows, one cycle after the sampling edge, the code of the sampled command. The codes are: 0 deselect (cs high), 1 NOP (ras, cas, we high), 2 activate (ras low), 3 read (cas low), 4 write (cas, we low), 5 precharge one bank (ras, we low, a10 low), 6 precharge all (same with a10 high), 7 refresh (ras, cas low), 8 mode write (ras, cas, we low, ba bit 0 low), 9 extended mode write (same with ba bit 0 high), 10 burst stop (we low), 11 clock enable low. All pins are active low, and "low" is stated with cs low unless cs is named.
- R2: Deselect and NOP change no bank state, but the bank timers keep running.
- R3: An activate is legal only to an idle bank. The bank then shows activating (1) for T_RCD cycles and then active (2). The bank state codes in `bank_st_o[3*b+:3]` are idle 0, activating 1, active 2, reading 3, writing 4, precharging 5.
- R4: A read or write is legal only to a bank that is active, reading or writing and has no auto-precharge pending. The bank then shows reading (3) or writing (4) for T_BURST cycles and then returns to active.
- R5: An illegal command sets `illegal_o` for one cycle and changes no bank state.
- R6: A read or write taken with a10 high sends the bank to precharging (5) when its burst ends, not to active.
- R7: A single-bank precharge closes the bank selected by `ba_i`. A precharge-all closes every open bank. A closed bank shows precharging for T_RP cycles and then idle. A bank that is already idle or precharging is not affected.
- R8: A mode or extended mode write is legal only when all banks are idle and clock enable was high at the previous edge.
- R9: A refresh is legal only when all banks are idle.
- R10: A burst stop is legal only while some bank is reading and no bank is writing. It ends the read burst at once.
- R11: A legal read or write to one bank ends any burst running in another bank, as if that burst had reached its end.
- R12: Clock enable low with all banks idle sets `pwrdn_o`, and clock enable high clears it. While clock enable is low, the command pins are ignored.
- R13: After reset, `cmd_o` is 0, `illegal_o` and `pwrdn_o` are low and all banks are idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Command clock, sampled on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank select |
| a10_i | input | 1 | Address bit 10: auto-precharge or precharge-all |
| cmd_o | output | 4 | Decoded command code (R1) |
| illegal_o | output | 1 | Command broke a legality rule |
| pwrdn_o | output | 1 | Power-down active |
| bank_st_o | output | 12 | Packed per-bank state, 3 bits per bank |

## Verification
The bench goes after these corner cases:
- A mode register write on the very edge after clock enable returns high. A design that looks only at the current clock enable would accept it.
- A burst stop during a write. A design that tests only for a running burst would end the write.
- A read issued during the activating window. A design that counts activating as open would start a burst too early.
- A precharge-all that lands on a bank still activating, and a read to one bank that cuts off a burst in another. A tracker that leaves those banks alone reports stale reading or activating states.
- A command presented while clock enable is low. A design that does not ignore it opens a bank.

// File: rtl/dram_cmd_pkg.sv
package dram_cmd_pkg;

  typedef enum logic [3:0] {
    CMD_DESEL = 4'd0,
    CMD_NOP   = 4'd1,
    CMD_ACT   = 4'd2,
    CMD_RD    = 4'd3,
    CMD_WR    = 4'd4,
    CMD_PRE   = 4'd5,
    CMD_PREA  = 4'd6,
    CMD_REF   = 4'd7,
    CMD_MRS   = 4'd8,
    CMD_EMRS  = 4'd9,
    CMD_BST   = 4'd10,
    CMD_CKEL  = 4'd11
  } cmd_e;

  typedef enum logic [2:0] {
    BK_IDLE   = 3'd0,
    BK_OPENING = 3'd1,
    BK_ACTIVE = 3'd2,
    BK_READ   = 3'd3,
    BK_WRITE  = 3'd4,
    BK_CLOSING = 3'd5
  } bank_st_e;

  localparam int unsigned BANK_ST_W = 3;

endpackage

// File: rtl/dram_cmd_decode.sv
module dram_cmd_decode
  import dram_cmd_pkg::*;
(
  input  logic cke_i,
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  input  logic ba0_i,
  input  logic a10_i,
  output cmd_e cmd_o
);

  always_comb begin
    if (!cke_i) begin
      cmd_o = CMD_CKEL;
    end else if (cs_ni) begin
      cmd_o = CMD_DESEL;
    end else begin
      case ({ras_ni, cas_ni, we_ni})
        3'b111:  cmd_o = CMD_NOP;
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b010:  cmd_o = a10_i ? CMD_PREA : CMD_PRE;
        3'b001:  cmd_o = CMD_REF;
        3'b000:  cmd_o = ba0_i ? CMD_EMRS : CMD_MRS;
        default: cmd_o = CMD_BST;
      endcase
    end
  end

endmodule

// File: rtl/dram_bank_fsm.sv
module dram_bank_fsm
  import dram_cmd_pkg::*;
#(
  parameter int unsigned T_RCD   = 2,
  parameter int unsigned T_RP    = 2,
  parameter int unsigned T_BURST = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     act_i,
  input  logic     rd_i,
  input  logic     wr_i,
  input  logic     ap_i,
  input  logic     pre_i,
  input  logic     cut_i,
  output bank_st_e state_o,
  output logic     ap_o
);

  localparam int unsigned T_MAX1 = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int unsigned T_MAX  = (T_MAX1 > T_BURST) ? T_MAX1 : T_BURST;
  localparam int unsigned CNT_W  = (T_MAX > 1) ? $clog2(T_MAX) : 1;
  localparam logic [CNT_W-1:0] LD_RCD = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] LD_BST = CNT_W'(T_BURST - 1);

  bank_st_e         st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ap_q;
  logic             bursting;

  assign bursting = (st_q == BK_READ) || (st_q == BK_WRITE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= BK_IDLE;
      cnt_q <= '0;
      ap_q  <= 1'b0;
    end else if (pre_i && st_q != BK_IDLE && st_q != BK_CLOSING) begin
      st_q  <= BK_CLOSING;
      cnt_q <= LD_RP;
      ap_q  <= 1'b0;
    end else if (act_i) begin
      st_q  <= BK_OPENING;
      cnt_q <= LD_RCD;
    end else if (rd_i || wr_i) begin
      st_q  <= rd_i ? BK_READ : BK_WRITE;
      cnt_q <= LD_BST;
      ap_q  <= ap_i;
    end else if (cut_i && bursting) begin
      st_q  <= ap_q ? BK_CLOSING : BK_ACTIVE;
      cnt_q <= LD_RP;
      ap_q  <= 1'b0;
    end else if (st_q != BK_IDLE && st_q != BK_ACTIVE) begin
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        case (st_q)
          BK_OPENING: st_q <= BK_ACTIVE;
          BK_CLOSING: st_q <= BK_IDLE;
          default: begin
            st_q  <= ap_q ? BK_CLOSING : BK_ACTIVE;
            cnt_q <= LD_RP;
            ap_q  <= 1'b0;
          end
        endcase
      end
    end
  end

  assign state_o = st_q;
  assign ap_o    = ap_q;

endmodule

// File: rtl/dram_cmd_tracker.sv
module dram_cmd_tracker
  import dram_cmd_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned T_RCD     = 2,
  parameter int unsigned T_RP      = 2,
  parameter int unsigned T_BURST   = 2,
  localparam int unsigned BA_W     = $clog2(NUM_BANKS),
  localparam int unsigned ST_W     = NUM_BANKS * BANK_ST_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cke_i,
  input  logic            cs_ni,
  input  logic            ras_ni,
  input  logic            cas_ni,
  input  logic            we_ni,
  input  logic [BA_W-1:0] ba_i,
  input  logic            a10_i,
  output logic [3:0]      cmd_o,
  output logic            illegal_o,
  output logic            pwrdn_o,
  output logic [ST_W-1:0] bank_st_o
);

  cmd_e     cmd_d;
  bank_st_e st   [NUM_BANKS];
  logic     ap   [NUM_BANKS];
  logic     all_idle, any_rd, any_wr, legal, cke_q;
  logic     open_sel;

  dram_cmd_decode u_dec (
    .cke_i  (cke_i),
    .cs_ni  (cs_ni),
    .ras_ni (ras_ni),
    .cas_ni (cas_ni),
    .we_ni  (we_ni),
    .ba0_i  (ba_i[0]),
    .a10_i  (a10_i),
    .cmd_o  (cmd_d)
  );

  always_comb begin
    all_idle = 1'b1;
    any_rd   = 1'b0;
    any_wr   = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      all_idle = all_idle & (st[b] == BK_IDLE);
      any_rd   = any_rd | (st[b] == BK_READ);
      any_wr   = any_wr | (st[b] == BK_WRITE);
    end
  end

  assign open_sel = (st[ba_i] == BK_ACTIVE || st[ba_i] == BK_READ ||
                     st[ba_i] == BK_WRITE) && !ap[ba_i];

  always_comb begin
    case (cmd_d)
      CMD_ACT:            legal = (st[ba_i] == BK_IDLE);
      CMD_RD, CMD_WR:     legal = open_sel;
      CMD_MRS, CMD_EMRS:  legal = all_idle && cke_q;
      CMD_REF:            legal = all_idle;
      CMD_BST:            legal = any_rd && !any_wr;
      default:            legal = 1'b1;
    endcase
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit, acc;
    assign hit = (ba_i == BA_W'(b));
    assign acc = legal && (cmd_d == CMD_RD || cmd_d == CMD_WR);

    dram_bank_fsm #(
      .T_RCD   (T_RCD),
      .T_RP    (T_RP),
      .T_BURST (T_BURST)
    ) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .act_i   (legal && cmd_d == CMD_ACT && hit),
      .rd_i    (legal && cmd_d == CMD_RD && hit),
      .wr_i    (legal && cmd_d == CMD_WR && hit),
      .ap_i    (a10_i),
      .pre_i   ((cmd_d == CMD_PRE && hit) || cmd_d == CMD_PREA),
      .cut_i   ((acc && !hit) || (legal && cmd_d == CMD_BST)),
      .state_o (st[b]),
      .ap_o    (ap[b])
    );

    assign bank_st_o[b*BANK_ST_W +: BANK_ST_W] = st[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o     <= CMD_DESEL;
      illegal_o <= 1'b0;
      pwrdn_o   <= 1'b0;
      cke_q     <= 1'b0;
    end else begin
      cmd_o     <= cmd_d;
      illegal_o <= !legal;
      cke_q     <= cke_i;
      if (pwrdn_o) begin
        if (cke_i) pwrdn_o <= 1'b0;
      end else if (!cke_i && all_idle) begin
        pwrdn_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dram_cmd_tracker_chk.sv
module dram_cmd_tracker_chk
  import dram_cmd_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  localparam int unsigned BA_W     = $clog2(NUM_BANKS),
  localparam int unsigned ST_W     = NUM_BANKS * BANK_ST_W
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cke_i,
  input logic [BA_W-1:0] ba_i,
  input logic [3:0]      cmd_o,
  input logic            illegal_o,
  input logic            pwrdn_o,
  input logic [ST_W-1:0] bank_st_o
);

  logic [2:0]      st_w [NUM_BANKS];
  logic            all_idle_w, any_rd_w, any_wr_w;
  logic [BA_W-1:0] ba_q;
  logic            cke_q;

  always_comb begin
    all_idle_w = 1'b1;
    any_rd_w   = 1'b0;
    any_wr_w   = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      st_w[b]    = bank_st_o[b*BANK_ST_W +: BANK_ST_W];
      all_idle_w = all_idle_w & (st_w[b] == BK_IDLE);
      any_rd_w   = any_rd_w | (st_w[b] == BK_READ);
      any_wr_w   = any_wr_w | (st_w[b] == BK_WRITE);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ba_q  <= '0;
      cke_q <= 1'b0;
    end else begin
      ba_q  <= ba_i;
      cke_q <= cke_i;
    end
  end

  // R8
  mode_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_o == CMD_MRS || cmd_o == CMD_EMRS) && !illegal_o) |->
      ($past(all_idle_w) && $past(cke_q)));

  // R9
  ref_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_REF && !illegal_o) |-> $past(all_idle_w));

  // R3
  act_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_ACT && !illegal_o) |->
      ($past(st_w[ba_i]) == BK_IDLE && st_w[ba_q] == BK_OPENING));

  // R4
  access_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_o == CMD_RD || cmd_o == CMD_WR) && !illegal_o) |->
      (st_w[ba_q] == ((cmd_o == CMD_RD) ? BK_READ : BK_WRITE)));

  // R10
  bst_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_BST && !illegal_o) |->
      ($past(any_rd_w) && !$past(any_wr_w) && !any_rd_w));

  // R12
  pd_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwrdn_o) |-> ($past(all_idle_w) && !$past(cke_i)));

  // R5
  illegal_scope_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (cmd_o == CMD_ACT || cmd_o == CMD_RD || cmd_o == CMD_WR ||
                   cmd_o == CMD_MRS || cmd_o == CMD_EMRS || cmd_o == CMD_REF ||
                   cmd_o == CMD_BST));

  // R13
  always_ff @(posedge clk_i) begin
    if (rst_ni) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        state_range_chk: assert (st_w[b] <= 3'd5);
      end
    end
  end

endmodule

bind dram_cmd_tracker dram_cmd_tracker_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cke_i     (cke_i),
  .ba_i      (ba_i),
  .cmd_o     (cmd_o),
  .illegal_o (illegal_o),
  .pwrdn_o   (pwrdn_o),
  .bank_st_o (bank_st_o)
);

// File: tb/dram_cmd_tracker_bench.sv
module dram_cmd_tracker_bench;

  localparam logic [3:0] P_DES  = 4'b1111;
  localparam logic [3:0] P_NOP  = 4'b0111;
  localparam logic [3:0] P_ACT  = 4'b0011;
  localparam logic [3:0] P_RD   = 4'b0101;
  localparam logic [3:0] P_WR   = 4'b0100;
  localparam logic [3:0] P_PRE  = 4'b0010;
  localparam logic [3:0] P_REF  = 4'b0001;
  localparam logic [3:0] P_MRS  = 4'b0000;
  localparam logic [3:0] P_BST  = 4'b0110;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b1;
  logic [3:0]  pins = P_DES;
  logic [1:0]  ba = '0;
  logic        a10 = 1'b0;
  logic [3:0]  cmd;
  logic        ill, pd;
  logic [11:0] bst;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [3:0] code;
    logic       ill;
    int         bk;
    logic [2:0] st;
    logic       pd;
    string      tag;
  } exp_t;

  exp_t q[$];

  always #5 clk = ~clk;

  dram_cmd_tracker u_dram_cmd_tracker (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .cke_i     (cke),
    .cs_ni     (pins[3]),
    .ras_ni    (pins[2]),
    .cas_ni    (pins[1]),
    .we_ni     (pins[0]),
    .ba_i      (ba),
    .a10_i     (a10),
    .cmd_o     (cmd),
    .illegal_o (ill),
    .pwrdn_o   (pd),
    .bank_st_o (bst)
  );

  task automatic issue(input logic [3:0] p, input logic ck, input logic [1:0] b,
                       input logic a, input logic [3:0] ecode, input logic eill,
                       input int ebk, input logic [2:0] est, input logic epd,
                       input string tag);
    exp_t e;
    @(negedge clk);
    pins = p; cke = ck; ba = b; a10 = a;
    e.code = ecode; e.ill = eill; e.bk = ebk; e.st = est; e.pd = epd; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: outputs of the edge that sampled the command
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        logic [2:0] st;
        e = q.pop_front();
        st = bst[e.bk*3 +: 3];
        checks++;
        if (cmd !== e.code || ill !== e.ill || st !== e.st || pd !== e.pd) begin
          errors++;
          $display("FAIL %s: cmd=%0d ill=%0b bank%0d=%0d pd=%0b expected cmd=%0d ill=%0b bank%0d=%0d pd=%0b",
                   e.tag, cmd, ill, e.bk, st, pd, e.code, e.ill, e.bk, e.st, e.pd);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    if (cmd !== 4'd0 || ill !== 1'b0 || pd !== 1'b0 || bst !== 12'd0) begin
      errors++;
      $display("FAIL R13: cmd=%0d ill=%0b pd=%0b st=%h expected 0 0 0 000", cmd, ill, pd, bst);
    end

    issue(P_NOP, 1, 0, 0, 1,  0, 0, 0, 0, "R2 nop");
    issue(P_NOP, 0, 0, 0, 11, 0, 0, 0, 1, "R12 pd entry");
    issue(P_MRS, 1, 0, 0, 8,  1, 0, 0, 0, "R8 mrs after cke low");
    issue(P_MRS, 1, 1, 0, 9,  0, 0, 0, 0, "R8 emrs legal");
    issue(P_ACT, 1, 0, 0, 2,  0, 0, 1, 0, "R3 act b0");
    issue(P_RD,  1, 0, 0, 3,  1, 0, 1, 0, "R5 rd while activating");
    issue(P_NOP, 1, 0, 0, 1,  0, 0, 2, 0, "R3 active after trcd");
    issue(P_MRS, 1, 0, 0, 8,  1, 0, 2, 0, "R8 mrs bank open");
    issue(P_REF, 1, 0, 0, 7,  1, 0, 2, 0, "R9 ref bank open");
    issue(P_RD,  1, 1, 0, 3,  1, 1, 0, 0, "R5 rd idle bank");
    issue(P_WR,  1, 0, 0, 4,  0, 0, 4, 0, "R4 wr b0");
    issue(P_BST, 1, 0, 0, 10, 1, 0, 4, 0, "R10 bst during write");
    issue(P_NOP, 1, 0, 0, 1,  0, 0, 2, 0, "R4 write burst end");
    issue(P_RD,  1, 0, 0, 3,  0, 0, 3, 0, "R4 rd b0");
    issue(P_BST, 1, 0, 0, 10, 0, 0, 2, 0, "R10 bst ends read");
    issue(P_RD,  1, 0, 1, 3,  0, 0, 3, 0, "R6 rd auto-pre");
    issue(P_NOP, 1, 0, 0, 1,  0, 0, 3, 0, "R6 still reading");
    issue(P_NOP, 1, 0, 0, 1,  0, 0, 5, 0, "R6 auto precharge");
    issue(P_NOP, 1, 0, 0, 1,  0, 0, 5, 0, "R7 trp hold");
    issue(P_NOP, 1, 0, 0, 1,  0, 0, 0, 0, "R7 idle after trp");
    issue(P_ACT, 1, 2, 0, 2,  0, 2, 1, 0, "R3 act b2");
    issue(P_ACT, 1, 2, 0, 2,  1, 2, 1, 0, "R5 act open bank");
    issue(P_NOP, 1, 0, 0, 1,  0, 2, 2, 0, "R3 b2 active");
    issue(P_ACT, 1, 3, 0, 2,  0, 3, 1, 0, "R3 act b3");
    issue(P_PRE, 1, 2, 0, 5,  0, 2, 5, 0, "R7 pre b2");
    issue(P_PRE, 1, 0, 1, 6,  0, 3, 5, 0, "R7 prea closes b3");
    issue(P_NOP, 1, 0, 0, 1,  0, 2, 0, 0, "R7 b2 idle");
    issue(P_NOP, 1, 0, 0, 1,  0, 3, 0, 0, "R7 b3 idle");
    issue(P_ACT, 1, 1, 0, 2,  0, 1, 1, 0, "R3 act b1");
    issue(P_ACT, 0, 2, 0, 11, 0, 1, 1, 0, "R12 cke low bank open");
    issue(P_NOP, 1, 0, 0, 1,  0, 1, 2, 0, "R12 timer ran");
    issue(P_NOP, 1, 0, 0, 1,  0, 2, 0, 0, "R12 act ignored");
    issue(P_PRE, 1, 0, 1, 6,  0, 1, 5, 0, "R7 prea b1");
    issue(P_NOP, 1, 0, 0, 1,  0, 1, 5, 0, "R7 b1 closing");
    issue(P_NOP, 1, 0, 0, 1,  0, 1, 0, 0, "R7 b1 idle");
    issue(P_REF, 1, 0, 0, 7,  0, 1, 0, 0, "R9 ref legal");
    issue(P_ACT, 1, 0, 0, 2,  0, 0, 1, 0, "R3 act b0 again");
    issue(P_ACT, 1, 1, 0, 2,  0, 1, 1, 0, "R3 act b1 again");
    issue(P_DES, 1, 0, 0, 0,  0, 0, 2, 0, "R2 deselect timers run");
    issue(P_NOP, 1, 0, 0, 1,  0, 1, 2, 0, "R3 b1 active");
    issue(P_RD,  1, 0, 0, 3,  0, 0, 3, 0, "R4 rd b0");
    issue(P_WR,  1, 1, 1, 4,  0, 0, 2, 0, "R11 wr b1 cuts b0");
    issue(P_NOP, 1, 0, 0, 1,  0, 1, 4, 0, "R11 b1 writing");
    issue(P_NOP, 1, 0, 0, 1,  0, 1, 5, 0, "R6 write auto-pre");
    issue(P_NOP, 1, 0, 0, 1,  0, 1, 5, 0, "R7 b1 closing");
    issue(P_NOP, 1, 0, 0, 1,  0, 1, 0, 0, "R7 b1 idle again");
    issue(P_NOP, 1, 0, 0, 1,  0, 0, 2, 0, "R1 final nop");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule